// File: doc/BRIEF.md
# DDR2 Extended Mode Register Tracker

This block sits on the controller side of a DDR2 memory interface. It observes every command the controller issues and keeps a shadow of the extended mode register, which it fills from load-mode commands aimed at that register. From the shadow it decodes the feature settings: DLL enable, output drive level, strobe configuration, output disable and termination value.

It also applies the timing rules tied to those settings. After a DLL reset, reads are held off for a fixed number of clocks while the DLL locks. Self refresh turns the DLL off, and leaving self refresh restarts the lock wait. When termination is first switched on, a short holdoff applies before the termination control pin may be raised. The block raises `read_ok` and `odt_ok` when these actions are legal. It pulses `violation` when the controller breaks one of the rules.

Top module: `ddr2_emr_tracker`

## Requirements
- R1: After synchronous reset the shadow register holds 14'h0001, so `dll_on`=0, `drive_reduced`=0, `strobe_n_on`=1, `rstrobe_on`=0, `rstrobe_n_on`=0, `outputs_off`=0 and `term_code`=00. `read_ok`, `odt_ok` and `violation` are all 0.
- R2: Command kinds are encoded as 0 load-mode, 1 read, 2 self-refresh entry and 3 self-refresh exit. A load-mode with `reg_sel`=1 replaces the shadow from the next cycle on. A load-mode with `reg_sel` of 0, 2 or 3 leaves the decoded settings unchanged. Bit 0 of the shadow is the DLL disable bit: `dll_on` is high when that bit is 0 and the device is not in self refresh.
- R3: Bit 1 of the shadow drives `drive_reduced`. A value of 1 means reduced drive, about 60 percent of full strength.
- R4: Bit 10 set to 1 clears `strobe_n_on`, which means single-ended strobe. Bit 11 drives `rstrobe_on`. `rstrobe_n_on` is high only when bit 11 is 1 and bit 10 is 0.
- R5: Bit 12 drives `outputs_off`. A value of 1 means all data and strobe outputs are disabled.
- R6: `term_code` is {bit 6, bit 2}. The codes are 00 off, 01 75 ohm, 10 150 ohm and 11 50 ohm.
- R7: A load-mode with `reg_sel`=0 and bit 8 set is a DLL reset. Counting the reset edge as edge 0, `read_ok` goes high after edge 199, provided the DLL is enabled. A read at edge 200 or later is therefore legal.
- R8: An extended load that changes the DLL enable bit clears the lock wait. Once the DLL is enabled again, `read_ok` stays low until a later DLL reset, however long the wait.
- R9: A read issued while `read_ok` is low sets `violation` for exactly the one cycle that follows the read edge.
- R10: Self-refresh entry forces `dll_on` and `read_ok` low. Self-refresh exit turns the DLL back on (when enabled) and restarts the 200-cycle wait, as a DLL reset does.
- R11: An extended load that moves `term_code` from 00 to a nonzero code holds `odt_ok` low for 8 cycles; `odt_ok` rises after the 8th edge that follows the load. A change between two nonzero codes applies no holdoff. `odt_ok` is low in self refresh and whenever termination is off.
- R12: `odt_in` high at a self-refresh entry edge, at any edge while in self refresh, or at any edge during the termination holdoff sets `violation` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | Command type: 0 load-mode, 1 read, 2 self-refresh entry, 3 self-refresh exit |
| reg_sel | input | 2 | Mode register targeted by a load-mode command |
| reg_value | input | 14 | Value carried by a load-mode command |
| odt_in | input | 1 | Level the controller drives on the termination control pin |
| dll_on | output | 1 | DLL enabled and running |
| drive_reduced | output | 1 | Reduced output drive selected |
| strobe_n_on | output | 1 | Complementary data strobe enabled |
| rstrobe_on | output | 1 | Redundant strobe enabled |
| rstrobe_n_on | output | 1 | Complementary redundant strobe enabled |
| outputs_off | output | 1 | Data and strobe outputs disabled |
| term_code | output | 2 | Termination selection |
| read_ok | output | 1 | A read command is legal now |
| odt_ok | output | 1 | The termination pin may be driven high now |
| violation | output | 1 | One-cycle pulse flagging a broken rule |

## Verification
The assertions assume that at most one command is issued per cycle and that `cmd_kind` only carries one of the four defined codes. The bench meets both by changing the command inputs only on the falling edge, through a task that issues a single command and then drops `cmd_valid`. The bench moves `odt_in` only between commands. This keeps every termination check tied to one known cycle relative to the holdoff and self-refresh state.

// File: rtl/emr_pkg.sv
package emr_pkg;

    localparam int VAL_W = 14;

    typedef enum logic [1:0] {
        CMD_LOAD     = 2'd0,
        CMD_READ     = 2'd1,
        CMD_SR_ENTER = 2'd2,
        CMD_SR_EXIT  = 2'd3
    } cmd_kind_e;

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_EXT  = 2'd1;

    localparam int BIT_DLL_OFF    = 0;
    localparam int BIT_DRIVE_LOW  = 1;
    localparam int BIT_TERM_LO    = 2;
    localparam int BIT_TERM_HI    = 6;
    localparam int BIT_STROBE_OFF = 10;
    localparam int BIT_RSTROBE    = 11;
    localparam int BIT_OUT_OFF    = 12;
    localparam int BIT_DLL_RESET  = 8;

    typedef struct packed {
        logic       dll_off;
        logic       drive_low;
        logic [1:0] term;
        logic       strobe_n_off;
        logic       rstrobe_en;
        logic       out_off;
    } emr_fields_t;

    localparam emr_fields_t EMR_RESET = '{dll_off: 1'b1, drive_low: 1'b0, term: 2'b00,
                                          strobe_n_off: 1'b0, rstrobe_en: 1'b0, out_off: 1'b0};

    function automatic emr_fields_t unpack_emr(input logic [VAL_W-1:0] v);
        emr_fields_t f;
        f.dll_off      = v[BIT_DLL_OFF];
        f.drive_low    = v[BIT_DRIVE_LOW];
        f.term         = {v[BIT_TERM_HI], v[BIT_TERM_LO]};
        f.strobe_n_off = v[BIT_STROBE_OFF];
        f.rstrobe_en   = v[BIT_RSTROBE];
        f.out_off      = v[BIT_OUT_OFF];
        return f;
    endfunction

endpackage

// File: rtl/emr_shadow.sv
module emr_shadow
    import emr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_ext,
    input  logic [VAL_W-1:0]  value,
    output emr_fields_t       fields_q,
    output emr_fields_t       fields_new
);
    assign fields_new = unpack_emr(value);

    always_ff @(posedge clk) begin
        if (rst)
            fields_q <= EMR_RESET;
        else if (load_ext)
            fields_q <= fields_new;
    end
endmodule

// File: rtl/dll_lock_tracker.sv
module dll_lock_tracker #(
    parameter int LOCK_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic dll_enabled,
    input  logic emr_load,
    input  logic new_dll_off,
    input  logic dll_reset_cmd,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic in_sref,
    output logic dll_running,
    output logic read_ok
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LOCK_V = CW'(LOCK_CYCLES);

    logic [CW-1:0] cnt;
    logic          dll_toggle;

    assign dll_toggle = emr_load && (new_dll_off == dll_enabled);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            in_sref <= 1'b0;
        end else if (sr_enter && !in_sref) begin
            in_sref <= 1'b1;
            cnt     <= '0;
        end else if (sr_exit && in_sref) begin
            in_sref <= 1'b0;
            cnt     <= dll_enabled ? CW'(1) : '0;
        end else if (dll_toggle) begin
            cnt <= '0;
        end else if (dll_reset_cmd && !in_sref) begin
            cnt <= CW'(1);
        end else if (cnt != '0 && cnt < LOCK_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign dll_running = dll_enabled && !in_sref;
    assign read_ok     = dll_running && (cnt == LOCK_V);

    AST_RESET_RELOCK: assert property (@(posedge clk) disable iff (rst)
        (dll_reset_cmd && !in_sref) |=> !read_ok); // R7
    AST_TOGGLE_NOLOCK: assert property (@(posedge clk) disable iff (rst)
        dll_toggle |=> !read_ok); // R8
    AST_SREF_EXIT_RELOCK: assert property (@(posedge clk) disable iff (rst)
        (sr_exit && in_sref) |=> !read_ok); // R10
endmodule

// File: rtl/odt_holdoff_tracker.sv
module odt_holdoff_tracker #(
    parameter int HOLDOFF = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_ext,
    input  logic [1:0] old_term,
    input  logic [1:0] new_term,
    input  logic       in_sref,
    output logic       odt_ok,
    output logic       holdoff_busy
);
    localparam int HW = $clog2(HOLDOFF + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLDOFF);

    logic [HW-1:0] hcnt;
    logic          term_turn_on;

    assign term_turn_on = load_ext && (new_term != 2'b00) && (old_term == 2'b00);

    always_ff @(posedge clk) begin
        if (rst)
            hcnt <= '0;
        else if (term_turn_on)
            hcnt <= HOLD_V;
        else if (load_ext && new_term == 2'b00)
            hcnt <= '0;
        else if (hcnt != '0)
            hcnt <= hcnt - 1'b1;
    end

    assign holdoff_busy = (hcnt != '0);
    assign odt_ok       = (old_term != 2'b00) && !holdoff_busy && !in_sref;

    AST_ODT_HOLD: assert property (@(posedge clk) disable iff (rst)
        term_turn_on |=> !odt_ok); // R11
endmodule

// File: rtl/violation_monitor.sv
module violation_monitor (
    input  logic clk,
    input  logic rst,
    input  logic is_read,
    input  logic read_ok,
    input  logic sr_enter,
    input  logic in_sref,
    input  logic odt_in,
    input  logic holdoff_busy,
    output logic violation
);
    logic read_bad;
    logic odt_bad;

    assign read_bad = is_read && !read_ok;
    assign odt_bad  = odt_in && (sr_enter || in_sref || holdoff_busy);

    always_ff @(posedge clk) begin
        if (rst)
            violation <= 1'b0;
        else
            violation <= read_bad || odt_bad;
    end
endmodule

// File: rtl/ddr2_emr_tracker.sv
module ddr2_emr_tracker
    import emr_pkg::*;
#(
    parameter int LOCK_CYCLES = 200,
    parameter int ODT_HOLDOFF = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_kind,
    input  logic [1:0]  reg_sel,
    input  logic [13:0] reg_value,
    input  logic        odt_in,
    output logic        dll_on,
    output logic        drive_reduced,
    output logic        strobe_n_on,
    output logic        rstrobe_on,
    output logic        rstrobe_n_on,
    output logic        outputs_off,
    output logic [1:0]  term_code,
    output logic        read_ok,
    output logic        odt_ok,
    output logic        violation
);
    cmd_kind_e   kind;
    logic        is_load, load_ext, dll_reset_cmd, is_read, sr_enter, sr_exit;
    emr_fields_t fields_q, fields_new;
    logic        in_sref, holdoff_busy;

    assign kind          = cmd_kind_e'(cmd_kind);
    assign is_load       = cmd_valid && (kind == CMD_LOAD);
    assign load_ext      = is_load && (reg_sel == SEL_EXT);
    assign dll_reset_cmd = is_load && (reg_sel == SEL_MODE) && reg_value[BIT_DLL_RESET];
    assign is_read       = cmd_valid && (kind == CMD_READ);
    assign sr_enter      = cmd_valid && (kind == CMD_SR_ENTER);
    assign sr_exit       = cmd_valid && (kind == CMD_SR_EXIT);

    emr_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .load_ext   (load_ext),
        .value      (reg_value),
        .fields_q   (fields_q),
        .fields_new (fields_new)
    );

    dll_lock_tracker #(.LOCK_CYCLES(LOCK_CYCLES)) u_dll (
        .clk           (clk),
        .rst           (rst),
        .dll_enabled   (!fields_q.dll_off),
        .emr_load      (load_ext),
        .new_dll_off   (fields_new.dll_off),
        .dll_reset_cmd (dll_reset_cmd),
        .sr_enter      (sr_enter),
        .sr_exit       (sr_exit),
        .in_sref       (in_sref),
        .dll_running   (dll_on),
        .read_ok       (read_ok)
    );

    odt_holdoff_tracker #(.HOLDOFF(ODT_HOLDOFF)) u_odt (
        .clk          (clk),
        .rst          (rst),
        .load_ext     (load_ext),
        .old_term     (fields_q.term),
        .new_term     (fields_new.term),
        .in_sref      (in_sref),
        .odt_ok       (odt_ok),
        .holdoff_busy (holdoff_busy)
    );

    violation_monitor u_viol (
        .clk          (clk),
        .rst          (rst),
        .is_read      (is_read),
        .read_ok      (read_ok),
        .sr_enter     (sr_enter),
        .in_sref      (in_sref),
        .odt_in       (odt_in),
        .holdoff_busy (holdoff_busy),
        .violation    (violation)
    );

    assign drive_reduced = fields_q.drive_low;
    assign strobe_n_on   = !fields_q.strobe_n_off;
    assign rstrobe_on    = fields_q.rstrobe_en;
    assign rstrobe_n_on  = fields_q.rstrobe_en && !fields_q.strobe_n_off;
    assign outputs_off   = fields_q.out_off;
    assign term_code     = fields_q.term;

    AST_EARLY_READ_FLAG: assert property (@(posedge clk) disable iff (rst)
        (is_read && !read_ok) |=> violation); // R9
    AST_SREF_ODT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (sr_enter && odt_in) |=> violation); // R12
    AST_SREF_DLL_OFF: assert property (@(posedge clk) disable iff (rst)
        sr_enter |=> !dll_on); // R10
endmodule

// File: tb/ddr2_emr_tracker_bench.sv
module ddr2_emr_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic [1:0]  reg_sel = 2'd0;
    logic [13:0] reg_value = 14'd0;
    logic        odt_in = 1'b0;
    logic        dll_on, drive_reduced, strobe_n_on, rstrobe_on, rstrobe_n_on, outputs_off;
    logic [1:0]  term_code;
    logic        read_ok, odt_ok, violation;

    int errors = 0;
    int checks = 0;

    localparam logic [1:0] K_LOAD = 2'd0, K_READ = 2'd1, K_SR_IN = 2'd2, K_SR_OUT = 2'd3;

    // {value, expected {dll_on,drive,strobe_n,rstrobe,rstrobe_n,out_off,term[1:0]}}
    localparam logic [21:0] VEC [11] = '{
        {14'h0000, 8'hA0}, {14'h0001, 8'h20}, {14'h0002, 8'hE0}, {14'h0004, 8'hA1},
        {14'h0040, 8'hA2}, {14'h0044, 8'hA3}, {14'h0400, 8'h80}, {14'h0800, 8'hB8},
        {14'h0C00, 8'h90}, {14'h1000, 8'hA4}, {14'h1FFF, 8'h57}
    };

    always #2.5 clk = ~clk;

    ddr2_emr_tracker u_ddr2_emr_tracker (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .reg_sel(reg_sel), .reg_value(reg_value), .odt_in(odt_in),
        .dll_on(dll_on), .drive_reduced(drive_reduced), .strobe_n_on(strobe_n_on),
        .rstrobe_on(rstrobe_on), .rstrobe_n_on(rstrobe_n_on), .outputs_off(outputs_off),
        .term_code(term_code), .read_ok(read_ok), .odt_ok(odt_ok), .violation(violation)
    );

    function automatic logic [7:0] fields();
        return {dll_on, drive_reduced, strobe_n_on, rstrobe_on, rstrobe_n_on, outputs_off, term_code};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [1:0] s, input logic [13:0] v);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; reg_sel = s; reg_value = v;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_odt(input logic v);
        @(negedge clk);
        odt_in = v;
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 fields", fields(), 8'h20);
        check("R1 read_ok", read_ok, 0);
        check("R1 odt_ok", odt_ok, 0);
        check("R1 violation", violation, 0);

        // R2..R6 decode table
        for (int i = 0; i < 11; i++) begin
            issue(K_LOAD, 2'd1, VEC[i][21:8]);
            check("R2 R3 R4 R5 R6 decode", fields(), VEC[i][7:0]);
        end

        // R7 lock wait
        issue(K_LOAD, 2'd1, 14'h0000);
        issue(K_LOAD, 2'd0, 14'h0100);
        check("R7 just after reset", read_ok, 0);
        idle(198);
        check("R7 after edge 198", read_ok, 0);
        idle(1);
        check("R7 after edge 199", read_ok, 1);
        issue(K_READ, 2'd0, 14'h0);
        check("R9 legal read", violation, 0);

        // R9 early read
        issue(K_LOAD, 2'd0, 14'h0100);
        issue(K_READ, 2'd0, 14'h0);
        check("R9 early read flagged", violation, 1);
        idle(1);
        check("R9 pulse one cycle", violation, 0);

        // R8 enable without reset
        issue(K_LOAD, 2'd1, 14'h0001);
        check("R8 dll off", dll_on, 0);
        issue(K_LOAD, 2'd1, 14'h0000);
        idle(250);
        check("R8 no lock without reset", read_ok, 0);
        issue(K_LOAD, 2'd0, 14'h0100);
        idle(199);
        check("R8 lock after reset", read_ok, 1);

        // R10 self refresh
        issue(K_SR_IN, 2'd0, 14'h0);
        check("R10 dll off in sref", dll_on, 0);
        check("R10 read_ok low in sref", read_ok, 0);
        issue(K_READ, 2'd0, 14'h0);
        check("R10 R9 read in sref", violation, 1);
        issue(K_SR_OUT, 2'd0, 14'h0);
        check("R10 dll back on", dll_on, 1);
        check("R10 relock starts", read_ok, 0);
        idle(198);
        check("R10 relock edge 198", read_ok, 0);
        idle(1);
        check("R10 relock edge 199", read_ok, 1);

        // R2 ignored loads
        issue(K_LOAD, 2'd0, 14'h0000);
        check("R2 mode load leaves fields", fields(), 8'hA0);
        issue(K_LOAD, 2'd2, 14'h1FFF);
        check("R2 sel 2 ignored", fields(), 8'hA0);
        check("R2 sel 2 keeps read_ok", read_ok, 1);

        // R11 termination holdoff
        issue(K_LOAD, 2'd1, 14'h0004);
        check("R11 holdoff start", odt_ok, 0);
        idle(7);
        check("R11 after edge 7", odt_ok, 0);
        idle(1);
        check("R11 after edge 8", odt_ok, 1);
        issue(K_LOAD, 2'd1, 14'h0044);
        check("R11 nonzero change no holdoff", odt_ok, 1);

        // R12 termination violations
        issue(K_LOAD, 2'd1, 14'h0000);
        check("R11 term off", odt_ok, 0);
        issue(K_LOAD, 2'd1, 14'h0004);
        set_odt(1'b1);
        check("R12 odt during holdoff", violation, 1);
        set_odt(1'b0);
        idle(8);
        set_odt(1'b1);
        check("R12 odt allowed", violation, 0);
        issue(K_SR_IN, 2'd0, 14'h0);
        check("R12 odt at sref entry", violation, 1);
        check("R11 odt_ok low in sref", odt_ok, 0);
        set_odt(1'b0);
        check("R12 odt low in sref", violation, 0);
        set_odt(1'b1);
        check("R12 odt high in sref", violation, 1);
        set_odt(1'b0);
        issue(K_SR_OUT, 2'd0, 14'h0);
        check("R11 odt_ok back after exit", odt_ok, 1);

        finish_run();
    end
endmodule